// File: doc/BRIEF.md
# Per-Channel Digital Gain for Raw Mosaic Pixels

This block scales a stream of 10-bit raw mosaic pixels by a small integer gain, then adds a programmable offset. Each pixel's gain comes from one of four channel registers. Which one is used depends on two parity inputs that give the odd or even row and column of the pixel. The result saturates at the 10-bit full scale.

The result leaves the block exactly two clocks after the pixel entered. The pixel-valid, line and frame markers travel through the same two register stages, so their timing is kept.

A simple register write port loads the four channel gains one at a time. A fifth address writes all four at once. A sixth address loads the offset. Each pixel is processed with the gain and offset values held in the registers at the clock edge that accepts it. A write on that same edge therefore affects only later pixels.

Top module: `bayer_dgain`

## Requirements
- R1: The channel gain is chosen from the parity inputs as follows:
  - (row even, column even) uses register address 0, the first green channel.
  - (row even, column odd) uses address 1, the red channel.
  - (row odd, column even) uses address 2, the blue channel.
  - (row odd, column odd) uses address 3, the second green channel.
- R2: A write to address 4 loads the same gain value into all four channel registers.
- R3: A write to one of addresses 0 to 3 changes only that channel register. When writes to one register follow each other, the last write wins, whether it was a single-channel write or a write to address 4.
- R4: A gain is an integer from 0 to 7 and is taken from wr_data[2:0]. The upper bits of wr_data are ignored for gain writes.
- R5: With a gain of 0, the output pixel equals the offset value alone.
- R6: The output pixel is pixel × gain + offset, clamped to 1023.
- R7: out_valid, out_lv and out_fv repeat in_valid, in_lv and in_fv exactly two clocks later. A pixel accepted on one edge appears on out_pix after the following edge.
- R8: out_pix is 0 whenever out_valid is low.
- R9: A synchronous active-high reset sets the following state:
  - All four gains are 1.
  - The offset is 0.
  - Every output is 0.
- R10: A write to address 5 loads the offset from wr_data[9:0]. Writes to addresses 6 and 7 change nothing.
- R11: A pixel uses the gain and offset values held before a write that happens on the same clock edge. The new values apply from the next accepted pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0-3 channels, 4 all channels, 5 offset) |
| wr_data | input | 10 | Write data |
| in_valid | input | 1 | Input pixel valid |
| in_lv | input | 1 | Input line marker |
| in_fv | input | 1 | Input frame marker |
| in_row_odd | input | 1 | Row parity of the input pixel |
| in_col_odd | input | 1 | Column parity of the input pixel |
| in_pix | input | 10 | Input raw pixel |
| out_valid | output | 1 | Output pixel valid |
| out_lv | output | 1 | Delayed line marker |
| out_fv | output | 1 | Delayed frame marker |
| out_pix | output | 10 | Gained, offset and clamped pixel |

## Verification
Suppose a channel register holds a wrong value, for example after a mis-decoded global write or a swapped parity decode. The error shows up on the first valid pixel of the affected parity, two clocks after that pixel enters. The stimulus therefore includes every parity combination after every kind of write.

A lost bit in the product or sum, or missing clamping, shows as a wrong out_pix value in the same cycle as out_valid. Large pixels with high gains and offsets provoke these faults. A marker pipeline with a missing or extra stage misaligns out_valid against the expected stream by one cycle on the first transition.

// File: rtl/bgain_pkg.sv
package bgain_pkg;
  localparam int NUM_CH = 4;

  typedef enum logic [2:0] {
    RA_GR    = 3'd0,
    RA_RED   = 3'd1,
    RA_BLUE  = 3'd2,
    RA_GB    = 3'd3,
    RA_ALL   = 3'd4,
    RA_OFFS  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic valid;
    logic lv;
    logic fv;
  } marks_t;
endpackage

// File: rtl/bgain_regbank.sv
module bgain_regbank
  import bgain_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int GAIN_W = 3,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [PIX_W-1:0]              wr_data,
  output logic [NUM_CH-1:0][GAIN_W-1:0] gain_q,
  output logic [PIX_W-1:0]              offs_q
);
  localparam logic [GAIN_W-1:0] GAIN_RST = GAIN_W'(1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en && ((wr_addr == ADDR_W'(c)) || (wr_addr == ADDR_W'(RA_ALL)));
    always_ff @(posedge clk) begin
      if (rst)      gain_q[c] <= GAIN_RST;
      else if (hit) gain_q[c] <= wr_data[GAIN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) offs_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(RA_OFFS)) offs_q <= wr_data;
  end

  // R2: global alias reaches every channel
  a_r2_global_alias: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(RA_ALL)) |=>
      (gain_q[0] == $past(wr_data[GAIN_W-1:0])) && (gain_q[1] == $past(wr_data[GAIN_W-1:0])) &&
      (gain_q[2] == $past(wr_data[GAIN_W-1:0])) && (gain_q[3] == $past(wr_data[GAIN_W-1:0])));

  // R3: a single-channel write lands in its own register
  a_r3_single_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < ADDR_W'(RA_ALL)) |=>
      gain_q[$past(wr_addr[1:0])] == $past(wr_data[GAIN_W-1:0]));

  // R10: unused addresses leave all state unchanged
  a_r10_unused_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > ADDR_W'(RA_OFFS)) |=> ($stable(gain_q) && $stable(offs_q)));
endmodule

// File: rtl/bgain_chan_sel.sv
module bgain_chan_sel
  import bgain_pkg::*;
#(
  parameter int GAIN_W = 3
) (
  input  logic [NUM_CH-1:0][GAIN_W-1:0] gain_q,
  input  logic                          row_odd,
  input  logic                          col_odd,
  output logic [GAIN_W-1:0]             gain_sel
);
  // row parity is the upper index bit, column parity the lower
  logic [1:0] idx;
  always_comb begin
    idx      = {row_odd, col_odd};
    gain_sel = gain_q[idx];
  end
endmodule

// File: rtl/bgain_pipe.sv
module bgain_pipe
  import bgain_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  marks_t            in_marks,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [GAIN_W-1:0] gain,
  input  logic [PIX_W-1:0]  offs,
  output marks_t            out_marks,
  output logic [PIX_W-1:0]  out_pix
);
  localparam int PROD_W = PIX_W + GAIN_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'((1 << PIX_W) - 1);

  marks_t            s1_marks;
  logic [PROD_W-1:0] s1_prod;
  logic [PIX_W-1:0]  s1_offs;
  logic [SUM_W-1:0]  sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_marks <= '0;
      s1_prod  <= '0;
      s1_offs  <= '0;
    end else begin
      s1_marks <= in_marks;
      s1_prod  <= PROD_W'(in_pix) * PROD_W'(gain);
      s1_offs  <= offs;
    end
  end

  always_comb sum = SUM_W'(s1_prod) + SUM_W'(s1_offs);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_marks <= '0;
      out_pix   <= '0;
    end else begin
      out_marks <= s1_marks;
      if (!s1_marks.valid)     out_pix <= '0;
      else if (sum > SAT_MAX)  out_pix <= PIX_W'(SAT_MAX);
      else                     out_pix <= sum[PIX_W-1:0];
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R7: markers delayed by exactly two clocks
  a_r7_marks_delay: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (out_marks == $past(in_marks, 2)));

  // R8: idle output is zero
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_marks.valid |-> (out_pix == '0));
endmodule

// File: rtl/bayer_dgain.sv
module bayer_dgain
  import bgain_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int GAIN_W = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIX_W-1:0]  wr_data,
  input  logic              in_valid,
  input  logic              in_lv,
  input  logic              in_fv,
  input  logic              in_row_odd,
  input  logic              in_col_odd,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_valid,
  output logic              out_lv,
  output logic              out_fv,
  output logic [PIX_W-1:0]  out_pix
);
  logic [NUM_CH-1:0][GAIN_W-1:0] gain_q;
  logic [PIX_W-1:0]              offs_q;
  logic [GAIN_W-1:0]             gain_sel;
  marks_t                        in_marks;
  marks_t                        out_marks;

  bgain_regbank #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .ADDR_W(ADDR_W)) u_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gain_q(gain_q), .offs_q(offs_q)
  );

  bgain_chan_sel #(.GAIN_W(GAIN_W)) u_chan_sel (
    .gain_q(gain_q), .row_odd(in_row_odd), .col_odd(in_col_odd), .gain_sel(gain_sel)
  );

  assign in_marks = '{valid: in_valid, lv: in_lv, fv: in_fv};

  bgain_pipe #(.PIX_W(PIX_W), .GAIN_W(GAIN_W)) u_pipe (
    .clk(clk), .rst(rst), .in_marks(in_marks), .in_pix(in_pix),
    .gain(gain_sel), .offs(offs_q), .out_marks(out_marks), .out_pix(out_pix)
  );

  assign out_valid = out_marks.valid;
  assign out_lv    = out_marks.lv;
  assign out_fv    = out_marks.fv;

  // R5: zero gain yields the offset captured with the pixel
  a_r5_zero_gain: assert property (@(posedge clk) disable iff (rst)
    (in_valid && gain_sel == '0) |=> ##1 (out_pix == $past(offs_q, 2)));
endmodule

// File: tb/bayer_dgain_bench.sv
module bayer_dgain_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [9:0] wr_data;
  logic       in_valid, in_lv, in_fv, in_row_odd, in_col_odd;
  logic [9:0] in_pix;
  logic       out_valid, out_lv, out_fv;
  logic [9:0] out_pix;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // model state
  int gm[4];
  int om;
  // expected pipeline: {valid, lv, fv, pix}
  logic [12:0] e1, e2;
  string tag;

  always #5 clk = ~clk;

  bayer_dgain u_bayer_dgain (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_valid(in_valid), .in_lv(in_lv), .in_fv(in_fv),
    .in_row_odd(in_row_odd), .in_col_odd(in_col_odd), .in_pix(in_pix),
    .out_valid(out_valid), .out_lv(out_lv), .out_fv(out_fv), .out_pix(out_pix)
  );

  function automatic int exp_pix(int p, int ro, int co);
    int v;
    v = p * gm[ro * 2 + co] + om;  // R1 index, R6 formula
    return (v > 1023) ? 1023 : v;
  endfunction

  function automatic void model_write(bit en, int a, int d);
    if (!en) return;
    if (a < 4) gm[a] = d & 7;
    else if (a == 4) for (int c = 0; c < 4; c++) gm[c] = d & 7;
    else if (a == 5) om = d;
  endfunction

  // one clock: check, advance model pipe, drive next inputs at negedge
  task automatic cyc(bit v, bit lv, bit fv, bit ro, bit co, int p, bit we, int wa, int wd);
    logic [12:0] act, nxt;
    @(negedge clk);
    act = {out_valid, out_lv, out_fv, out_pix};
    checks++;
    if (act !== e2) begin
      errors++;
      $display("FAIL %s: got v=%0b lv=%0b fv=%0b pix=%0d expected v=%0b lv=%0b fv=%0b pix=%0d",
               tag, act[12], act[11], act[10], act[9:0], e2[12], e2[11], e2[10], e2[9:0]);
    end
    e2 = e1;
    nxt = {v, lv, fv, 10'd0};
    if (v) nxt[9:0] = 10'(exp_pix(p, ro, co));
    e1 = nxt;
    in_valid = v; in_lv = lv; in_fv = fv; in_row_odd = ro; in_col_odd = co; in_pix = 10'(p);
    wr_en = we; wr_addr = 3'(wa); wr_data = 10'(wd);
    model_write(we, wa, wd);  // R11: takes effect after this pixel
  endtask

  task automatic px(bit ro, bit co, int p);
    cyc(1, 1, 1, ro, co, p, 0, 0, 0);
  endtask

  task automatic wr(int a, int d);
    cyc(0, 0, 1, 0, 0, 0, 1, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic all_parity(int p);
    px(0, 0, p); px(0, 1, p); px(1, 0, p); px(1, 1, p);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) gm[c] = 1;
    om = 0;
    e1 = '0; e2 = '0;
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0;
    in_valid = 0; in_lv = 0; in_fv = 0; in_row_odd = 0; in_col_odd = 0; in_pix = 0;
    tag = "R9";
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    idle(2);                               // R9 reset outputs zero
    all_parity(1023); idle(2);             // R9 gain 1, offset 0

    tag = "R1";                            // R1/R3/R4 distinct gains, upper bits ignored
    wr(0, 10'h3F8 | 2); wr(1, 10'h2A8 | 3); wr(2, 4); wr(3, 10'h100 | 5);
    all_parity(100); all_parity(37); idle(2);

    tag = "R3";
    wr(1, 6); wr(1, 1);                    // last write wins, others untouched
    all_parity(50); idle(2);

    tag = "R2";
    wr(4, 6); all_parity(77); idle(1);
    wr(2, 2); all_parity(77); idle(2);     // R3 mixed global then single

    tag = "R5";
    wr(4, 8); wr(5, 37);                   // 8 -> gain field 0
    all_parity(999); idle(2);

    tag = "R6";
    wr(4, 7); wr(5, 1000);
    all_parity(1023); all_parity(3); all_parity(0); idle(2);
    wr(5, 0); all_parity(146); all_parity(147); idle(2);

    tag = "R10";
    wr(6, 5); wr(7, 1000);
    all_parity(40); idle(2);

    tag = "R11";                           // write on same edge as a pixel
    cyc(1, 1, 1, 0, 0, 20, 1, 0, 3);
    cyc(1, 1, 1, 0, 0, 20, 1, 5, 9);
    cyc(1, 1, 1, 0, 0, 20, 0, 0, 0);
    idle(2);

    tag = "R7";                            // random stream incl. markers and writes
    begin
      int unsigned s;
      s = $urandom(32'd1234);
      for (int i = 0; i < 4000; i++) begin
        bit v, lv, fv, we;
        v  = 1'($urandom % 2); lv = 1'($urandom % 2); fv = 1'($urandom % 2);
        we = (($urandom % 8) == 0);
        cyc(v, lv, fv, 1'($urandom % 2), 1'($urandom % 2), int'($urandom % 1024),
            we, int'($urandom % 8), int'($urandom % 1024));
      end
    end
    tag = "R8";
    idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule